// File: doc/BRIEF.md
# SAR Conversion Timing Controller

This block runs the digital side of one successive-approximation conversion cycle. A falling edge on an active-low convert-start input begins a conversion. A busy flag is raised, and the block counts out a conversion phase whose length depends on a speed mode taken from two select pins. It then copies the word offered by the analog core model into an output register. After that it drops busy and pulses a data-valid strobe. A fixed acquisition window follows, and any new start that falls inside it is discarded.

In the fastest mode, accuracy depends on conversions following each other closely enough. The block measures the gap between accepted starts. A fast-mode conversion that begins after too long a gap is flagged. All durations are given in nanoseconds and turned into cycles of the system clock, rounded up. At the default 20 ns clock the conversion phase lasts 50, 63 or 75 cycles for the fast, normal and low-power modes, and acquisition lasts 13 cycles.

Top module: `sar_conv_timing`

## Requirements
- R1: The mode is decoded from `sel_fast` and `sel_lowpwr` at the start edge. (1,0) selects fast, (0,1) selects low-power, and (0,0) or (1,1) select normal.
- R2: A start is accepted only on a falling edge of `cnv_start_n` (high at the previous clock edge, low at this one) while the block is idle. `busy` reads 1 from the accepting edge onward. Holding `cnv_start_n` low starts nothing further.
- R3: `busy` stays high for C+1 cycles, where C is the conversion cycle count for the mode (default 50 fast, 63 normal, 75 low-power).
- R4: `result` takes `core_result` at the clock edge that ends the conversion phase. This is one cycle before `busy` falls. At all other times `result` holds its value.
- R5: `data_valid` is a single-cycle pulse in the first cycle in which `busy` is low after a conversion.
- R6: For 13 cycles after `busy` falls, and while `busy` is high, a start edge is ignored. The earliest accepted start comes C+15 edges after the previous accepted start.
- R7: At each accepted start, `warp_stale` is set to 1 if the mode is fast and more than WARP_IDLE_NS worth of cycles have passed since the previous accepted start (or since reset). Otherwise it is set to 0. It holds that value until the next accepted start.
- R8: A low `rst_n` at a clock edge aborts any conversion. It clears `busy`, `result`, `data_valid` and `warp_stale`, and no data-valid pulse follows.
- R9: Changing the select pins during a conversion does not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cnv_start_n | input | 1 | Convert-start strobe, acts on its falling edge |
| sel_fast | input | 1 | Speed select, fast side |
| sel_lowpwr | input | 1 | Speed select, low-power side |
| core_result | input | 18 | Word from the analog core model |
| busy | output | 1 | High while a conversion is in progress |
| result | output | 18 | Latched conversion word |
| data_valid | output | 1 | One-cycle pulse as busy falls |
| warp_stale | output | 1 | Fast-mode conversion began after too long a gap |

## Verification
The hardest conditions to reach are the exact edges of two windows. One is the last acquisition cycle, where a start must still be dropped, followed by the very next cycle, where it must be taken. The other is the idle-gap limit, tested at exactly the limit and at one cycle beyond it. The bench reaches both by driving starts on falling clock edges at counted offsets from the previous accepted start. It also shortens the idle limit through its parameter so that both gap lengths fit in a short run.

// File: rtl/sar_ctl_pkg.sv
// Shared types and helpers for the SAR conversion timing controller.
// Assumes durations are given in whole nanoseconds.
package sar_ctl_pkg;

    typedef enum logic [1:0] {
        SPD_NORMAL = 2'd0,
        SPD_FAST   = 2'd1,
        SPD_LOWPWR = 2'd2
    } speed_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CONV  = 2'd1,
        PH_LATCH = 2'd2,
        PH_ACQ   = 2'd3
    } phase_e;

    // Decode the two select pins; both high falls back to normal.
    function automatic speed_e decode_speed(input logic fast, input logic lowpwr);
        if (fast && !lowpwr)      return SPD_FAST;
        else if (lowpwr && !fast) return SPD_LOWPWR;
        else                      return SPD_NORMAL;
    endfunction

    // Convert a duration to clock cycles, rounding up.
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

endpackage

// File: rtl/sar_start_detect.sv
// Falling-edge detector for the active-low convert-start strobe.
// Assumes cnv_start_n is already synchronous to clk.
module sar_start_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic cnv_start_n,
    output logic start_evt
);

    logic prev_q;

    // Remember the strobe level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= cnv_start_n;
    end

    assign start_evt = prev_q && !cnv_start_n;

endmodule

// File: rtl/sar_phase_seq.sv
// Phase sequencer: idle -> conversion -> latch -> acquisition -> idle.
// The conversion length is fixed at the accepting edge. Starts outside
// the idle phase are dropped.
module sar_phase_seq #(
    parameter int unsigned CONV_FAST_CYC = 50,
    parameter int unsigned CONV_NORM_CYC = 63,
    parameter int unsigned CONV_LOW_CYC  = 75,
    parameter int unsigned ACQ_CYC       = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_evt,
    input  sar_ctl_pkg::speed_e speed_sel,
    output logic                accept,
    output logic                busy,
    output logic                latch_en,
    output logic                data_valid
);
    import sar_ctl_pkg::*;

    localparam int unsigned MAX_A = (CONV_FAST_CYC > CONV_NORM_CYC) ? CONV_FAST_CYC : CONV_NORM_CYC;
    localparam int unsigned MAX_B = (CONV_LOW_CYC > ACQ_CYC) ? CONV_LOW_CYC : ACQ_CYC;
    localparam int unsigned MAX_C = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int unsigned TW    = $clog2(MAX_C + 1);
    localparam logic [TW-1:0] ACQ_LAST = TW'(ACQ_CYC - 1);

    phase_e        phase_q;
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] conv_last_q;
    logic [TW-1:0] conv_last_d;
    logic          dv_q;

    // Pick the last conversion cycle index for the requested mode.
    always_comb begin
        case (speed_sel)
            SPD_FAST:   conv_last_d = TW'(CONV_FAST_CYC - 1);
            SPD_LOWPWR: conv_last_d = TW'(CONV_LOW_CYC - 1);
            default:    conv_last_d = TW'(CONV_NORM_CYC - 1);
        endcase
    end

    assign accept   = start_evt && (phase_q == PH_IDLE);
    assign busy     = (phase_q == PH_CONV) || (phase_q == PH_LATCH);
    assign latch_en = (phase_q == PH_CONV) && (tmr_q == conv_last_q);
    assign data_valid = dv_q;

    // Advance the phase and its cycle timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            tmr_q       <= '0;
            conv_last_q <= '0;
            dv_q        <= 1'b0;
        end else begin
            dv_q <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (accept) begin
                        phase_q     <= PH_CONV;
                        tmr_q       <= '0;
                        conv_last_q <= conv_last_d;
                    end
                end
                PH_CONV: begin
                    if (tmr_q == conv_last_q) begin
                        phase_q <= PH_LATCH;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
                PH_LATCH: begin
                    phase_q <= PH_ACQ;
                    tmr_q   <= '0;
                    dv_q    <= 1'b1;
                end
                default: begin
                    if (tmr_q == ACQ_LAST) begin
                        phase_q <= PH_IDLE;
                        tmr_q   <= '0;
                    end else begin
                        tmr_q <= tmr_q + 1'b1;
                    end
                end
            endcase
        end
    end

    AST_DV_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid); // R5
    AST_DV_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |-> (!busy && $past(busy))); // R5
    AST_LATCH_BEFORE_ACQ: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_ACQ) && $past(phase_q == PH_IDLE) |-> 1'b0); // R6

endmodule

// File: rtl/sar_result_reg.sv
// Output word register, loaded once per conversion.
// Assumes latch_en is a single-cycle pulse.
module sar_result_reg #(
    parameter int unsigned DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    // Capture the core word on the latch pulse, hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= '0;
        else if (latch_en) q <= d;
    end

endmodule

// File: rtl/sar_warp_monitor.sv
// Measures the gap between accepted starts and flags a fast-mode start
// that follows a gap longer than LIMIT_CYC. The counter saturates.
module sar_warp_monitor #(
    parameter int unsigned LIMIT_CYC = 50000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic is_fast,
    output logic stale
);

    localparam int unsigned CW = $clog2(LIMIT_CYC + 2);
    localparam logic [CW-1:0] LIM_V = CW'(LIMIT_CYC);

    logic [CW-1:0] gap_q;

    // Count cycles since the last accepted start and grade each new start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
            stale <= 1'b0;
        end else if (accept) begin
            gap_q <= CW'(1);
            stale <= is_fast && (gap_q > LIM_V);
        end else if (gap_q <= LIM_V) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_STALE_NEEDS_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stale) |-> $past(accept && is_fast)); // R7

endmodule

// File: rtl/sar_conv_timing.sv
// Top of the SAR conversion timing controller. It turns nanosecond
// durations into cycle counts and wires the start detector, the phase
// sequencer, the result register and the idle-gap monitor together.
// Assumes all inputs are synchronous to clk.
module sar_conv_timing #(
    parameter int unsigned CLK_PERIOD_NS = 20,
    parameter int unsigned DATA_W        = 18,
    parameter int unsigned CONV_FAST_NS  = 1000,
    parameter int unsigned CONV_NORM_NS  = 1250,
    parameter int unsigned CONV_LOW_NS   = 1500,
    parameter int unsigned ACQ_NS        = 250,
    parameter int unsigned WARP_IDLE_NS  = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_start_n,
    input  logic              sel_fast,
    input  logic              sel_lowpwr,
    input  logic [DATA_W-1:0] core_result,
    output logic              busy,
    output logic [DATA_W-1:0] result,
    output logic              data_valid,
    output logic              warp_stale
);
    import sar_ctl_pkg::*;

    localparam int unsigned CONV_FAST_CYC = ns_to_cycles(CONV_FAST_NS, CLK_PERIOD_NS);
    localparam int unsigned CONV_NORM_CYC = ns_to_cycles(CONV_NORM_NS, CLK_PERIOD_NS);
    localparam int unsigned CONV_LOW_CYC  = ns_to_cycles(CONV_LOW_NS, CLK_PERIOD_NS);
    localparam int unsigned ACQ_CYC       = ns_to_cycles(ACQ_NS, CLK_PERIOD_NS);
    localparam int unsigned WARP_CYC      = ns_to_cycles(WARP_IDLE_NS, CLK_PERIOD_NS);

    logic   start_evt;
    logic   accept;
    logic   latch_en;
    speed_e speed;

    assign speed = decode_speed(sel_fast, sel_lowpwr);

    sar_start_detect u_start (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start_n (cnv_start_n),
        .start_evt   (start_evt)
    );

    sar_phase_seq #(
        .CONV_FAST_CYC (CONV_FAST_CYC),
        .CONV_NORM_CYC (CONV_NORM_CYC),
        .CONV_LOW_CYC  (CONV_LOW_CYC),
        .ACQ_CYC       (ACQ_CYC)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .speed_sel  (speed),
        .accept     (accept),
        .busy       (busy),
        .latch_en   (latch_en),
        .data_valid (data_valid)
    );

    sar_result_reg #(
        .DATA_W (DATA_W)
    ) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .d        (core_result),
        .q        (result)
    );

    sar_warp_monitor #(
        .LIMIT_CYC (WARP_CYC)
    ) u_warp (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .is_fast (speed == SPD_FAST),
        .stale   (warp_stale)
    );

    AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_evt)); // R2
    AST_RESULT_STEADY_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && $past(rst_n) |-> $stable(result)); // R4
    AST_RESULT_MOVES_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) && $past(rst_n) |-> busy); // R4
    AST_STALE_ONLY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(warp_stale) && $past(rst_n) |-> $rose(busy)); // R7

endmodule

// File: tb/sim_sar_conv_timing.sv
// Directed bench for sar_conv_timing. Inputs change on falling clock
// edges and outputs are sampled there.
module sim_sar_conv_timing;

    localparam int PER     = 20;
    localparam int C_FAST  = (1000 + PER - 1) / PER;
    localparam int C_NORM  = (1250 + PER - 1) / PER;
    localparam int C_LOW   = (1500 + PER - 1) / PER;
    localparam int ACQ     = (250 + PER - 1) / PER;
    localparam int LIM     = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnv_start_n = 1'b1;
    logic        sel_fast = 1'b0;
    logic        sel_lowpwr = 1'b0;
    logic [17:0] core_result = '0;
    logic        busy;
    logic [17:0] result;
    logic        data_valid;
    logic        warp_stale;

    int checks = 0;
    int errors = 0;

    always #(PER/2) clk = ~clk;

    sar_conv_timing #(
        .CLK_PERIOD_NS (PER),
        .WARP_IDLE_NS  (LIM * PER)
    ) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cnv_start_n (cnv_start_n),
        .sel_fast    (sel_fast),
        .sel_lowpwr  (sel_lowpwr),
        .core_result (core_result),
        .busy        (busy),
        .result      (result),
        .data_valid  (data_valid),
        .warp_stale  (warp_stale)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One-cycle low strobe; called and returning at a falling edge.
    task automatic do_pulse();
        cnv_start_n = 1'b0;
        @(negedge clk);
        cnv_start_n = 1'b1;
    endtask

    // Full conversion with checks. Ends on the last cycle in which a start is still dropped.
    task automatic run_conv(input logic f, input logic l, input int c,
                            input logic [17:0] val, input logic exp_stale, input string tag);
        logic [17:0] old;
        old = result;
        sel_fast = f; sel_lowpwr = l; core_result = val;
        do_pulse();
        chk("R2", {tag, " busy after start"}, busy, 1);
        chk("R7", {tag, " stale flag"}, warp_stale, exp_stale);
        sel_fast = ~f; sel_lowpwr = ~l;  // R9: mode pins move mid-conversion
        repeat (c - 1) @(negedge clk);
        chk("R3", {tag, " busy late"}, busy, 1);
        chk("R4", {tag, " result held"}, result, old);
        @(negedge clk);
        chk("R3", {tag, " busy in latch cycle"}, busy, 1);
        chk("R4", {tag, " result latched"}, result, val);
        @(negedge clk);
        chk("R9", {tag, " busy fell on time"}, busy, 0);
        chk("R5", {tag, " valid pulse"}, data_valid, 1);
        core_result = ~val;
        @(negedge clk);
        chk("R5", {tag, " valid single"}, data_valid, 0);
        chk("R4", {tag, " result kept"}, result, val);
        repeat (ACQ - 2) @(negedge clk);
    endtask

    task automatic t_reset();
        repeat (4) @(negedge clk);
        chk("R8", "busy in reset", busy, 0);
        chk("R8", "result in reset", result, 0);
        chk("R8", "valid in reset", data_valid, 0);
        chk("R8", "stale in reset", warp_stale, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "busy after release", busy, 0);
    endtask

    task automatic t_modes();
        run_conv(1, 0, C_FAST, 18'h2A5A5, 0, "R1 fast");
        @(negedge clk);
        run_conv(0, 0, C_NORM, 18'h15A5A, 0, "R1 normal");
        @(negedge clk);
        run_conv(0, 1, C_LOW, 18'h3FFFF, 0, "R1 lowpwr");
        @(negedge clk);
        run_conv(1, 1, C_NORM, 18'h00001, 0, "R1 both");
    endtask

    task automatic t_acq_edges();
        do_pulse();  // lands on the final acquisition cycle
        chk("R6", "start in acquisition dropped", busy, 0);
        repeat (5) @(negedge clk);
        chk("R6", "still idle", busy, 0);
        run_conv(0, 0, C_NORM, 18'h0BEEF, 0, "R6 prep");
        @(negedge clk);
        run_conv(0, 0, C_NORM, 18'h1CAFE, 0, "R6 earliest start");
    endtask

    task automatic t_ignore_busy();
        @(negedge clk);
        sel_fast = 1; sel_lowpwr = 0; core_result = 18'h12345;
        do_pulse();
        repeat (10) @(negedge clk);
        do_pulse();  // during conversion, edge a+11
        repeat (C_FAST - 11) @(negedge clk);
        chk("R6", "busy unchanged by extra start", busy, 1);
        @(negedge clk);
        chk("R6", "busy fell at first schedule", busy, 0);
        chk("R6", "result from first start", result, 18'h12345);
        repeat (ACQ + 2) @(negedge clk);
        chk("R6", "no second conversion", busy, 0);
    endtask

    task automatic t_hold_low();
        sel_fast = 0; sel_lowpwr = 0;
        cnv_start_n = 1'b0;
        @(negedge clk);
        chk("R2", "edge starts", busy, 1);
        repeat (C_NORM + ACQ + 10) @(negedge clk);
        chk("R2", "level low starts nothing", busy, 0);
        chk("R2", "no extra valid", data_valid, 0);
        cnv_start_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_abort();
        bit bad;
        sel_fast = 0; sel_lowpwr = 0; core_result = 18'h2FFFF;
        do_pulse();
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R8", "busy aborted", busy, 0);
        chk("R8", "result cleared", result, 0);
        bad = 0;
        for (int i = 0; i < C_NORM + 4; i++) begin
            @(negedge clk);
            if (busy || data_valid || result != 0) bad = 1;
        end
        chk("R8", "no completion after abort", {31'd0, bad}, 0);
        run_conv(0, 0, C_NORM, 18'h0F0F0, 0, "R8 restart");
    endtask

    task automatic t_warp();
        // run_conv ends C+ACQ edges after its accept edge
        @(negedge clk);
        run_conv(1, 0, C_FAST, 18'h11111, 0, "R7 base");
        repeat (LIM - 1 - (C_FAST + ACQ)) @(negedge clk);
        run_conv(1, 0, C_FAST, 18'h22222, 0, "R7 gap at limit");
        repeat (LIM - (C_FAST + ACQ)) @(negedge clk);
        run_conv(1, 0, C_FAST, 18'h33333, 1, "R7 gap over limit");
        chk("R7", "flag held after conversion", warp_stale, 1);
        repeat (300) @(negedge clk);
        run_conv(0, 0, C_NORM, 18'h04444, 0, "R7 long gap normal");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_modes();
        t_acq_edges();
        t_ignore_busy();
        t_hold_low();
        t_abort();
        t_warp();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule